// File: doc/BRIEF.md
# Disk DMA Channel With Arbitration

This block is a bus-master DMA engine that sits between system memory and a disk controller. It moves one byte at a time under the controller's request/acknowledge handshake. The controller's phase lines decide what happens to each byte. In data phase, the direction line picks either a memory read (the byte goes to the controller) or a memory write (the controller's byte goes to memory). In command phase the channel takes in the completion status and the final message byte. No host-programmed byte count or direction is involved.

Before a transfer, the host loads a 24-bit memory pointer one byte per write, most significant byte first. The host can also zero the pointer with a single clear strobe. For each data byte the channel requests the system bus with a hold request and drives its 4-bit priority code onto the arbitration lines. It owns the bus once hold-acknowledge arrives and the lines carry its own code. A burst-mode input chooses between keeping the bus for the whole data phase and giving it back after every byte. Slow memory stretches the strobe through a ready input. At the end of the command, the status byte is captured, the done flag is set and an optional interrupt is raised.

Top module: `disk_dma_channel`

## Requirements
- R1: With `wide_mode`=1, three pointer writes load bits 23..16, 15..8 and 7..0 in that order. With `wide_mode`=0, two writes load bits 15..8 then 7..0, and bits 23..16 become zero.
- R2: A pulse on `addr_clr` sets the pointer to zero on the next clock, even when a pointer write happens in the same cycle.
- R3: The channel raises `hold_req` only when `dma_en`=1 and the controller shows `ctl_req`=1 with `ctl_cmd`=0. With `dma_en`=0 a data request leaves `hold_req` low.
- R4: While `hold_req` is high, `arb_code_out` equals `prio`. The bus is won when `hold_ack`=1 and `arb_code_in`=`prio`. If `hold_ack`=1 with any other code, the channel drops `hold_req` and asks again once `hold_ack` is low; no memory strobe occurs until it wins.
- R5: With `burst_mode`=1, `hold_req` stays high between data bytes. With `burst_mode`=0 it is low in the cycle after the controller removes its request.
- R6: With `ctl_in`=1 the channel asserts `mem_rd` and presents the fetched byte on `ctl_dout`. With `ctl_in`=0 it asserts `mem_wr` with `mem_wdata`=`ctl_din`. Never both.
- R7: While `mem_ready`=0 the active strobe and `mem_addr` hold steady. The byte completes in the cycle where `mem_ready`=1.
- R8: The pointer (`mem_addr`) advances by one after each completed byte and wraps from 24'hFFFFFF to 0.
- R9: A request with `ctl_cmd`=1 and `ctl_msg`=0 while enabled releases the bus and stores `ctl_din` into `cstat`.
- R10: A request with `ctl_cmd`=1 and `ctl_msg`=1 while enabled sets `done`. It sets `irq` only if `irq_en`=1.
- R11: `done` reads 1 whenever `dma_en`=0, including after reset. A rising `dma_en` clears `done` and `irq`.
- R12: `ctl_ack` rises after a byte (data, status or message) is accepted and stays high until `ctl_req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dma_en | input | 1 | Channel enable |
| irq_en | input | 1 | Interrupt enable for the message byte |
| burst_mode | input | 1 | 1 keeps the bus across bytes |
| wide_mode | input | 1 | 1 = three-byte pointer load, 0 = two-byte |
| prio | input | 4 | Arbitration priority code |
| addr_wr | input | 1 | Pointer byte write strobe |
| addr_wdata | input | 8 | Pointer byte |
| addr_clr | input | 1 | Pointer clear strobe |
| ctl_req | input | 1 | Controller request |
| ctl_in | input | 1 | 1 = data toward controller |
| ctl_cmd | input | 1 | 1 = command/status phase |
| ctl_msg | input | 1 | Last byte marker |
| ctl_din | input | 8 | Byte from controller |
| ctl_dout | output | 8 | Byte to controller |
| ctl_ack | output | 1 | Handshake acknowledge |
| hold_req | output | 1 | Bus hold request |
| hold_ack | input | 1 | Bus hold acknowledge |
| arb_code_out | output | 4 | Priority code driven while requesting |
| arb_code_in | input | 4 | Code observed on arbitration lines |
| mem_addr | output | 24 | Memory address (the pointer) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_ready | input | 1 | Memory ready |
| done | output | 1 | Done flag |
| irq | output | 1 | Interrupt |
| cstat | output | 8 | Captured completion status |

## Verification
The properties assume a well-behaved controller. It holds `ctl_req` and keeps its phase lines and data stable until it sees `ctl_ack`, and it removes the request before presenting the next byte. They also assume that pointer writes and clears happen only when no strobe is active, and that `hold_ack` follows `hold_req`. The stimulus meets these assumptions as follows. The controller model in the bench waits for the acknowledge before releasing each byte. The bus model answers a request one cycle later. Pointer loads and enable changes are issued only when the channel is idle. Losing arbitration is produced by placing a foreign code on the arbitration lines.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_BACKOFF,
        ST_OWN,
        ST_STROBE,
        ST_HSK_END,
        ST_STAT_END
    } chan_state_e;
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
    parameter int ADDR_W = 24,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              clr,
    input  logic              wide,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);
    localparam int NARROW_W = 2 * BYTE_W;

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (clr) begin
            addr_d = '0;
        end else if (wr) begin
            if (wide) addr_d = {addr_q[ADDR_W-BYTE_W-1:0], wdata};
            else      addr_d = ADDR_W'({addr_q[NARROW_W-BYTE_W-1:0], wdata});
        end else if (inc) begin
            addr_d = addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;
endmodule

// File: rtl/dma_status_unit.sv
module dma_status_unit #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              irq_en,
    input  logic              stat_cap,
    input  logic              msg_cap,
    input  logic [DATA_W-1:0] stat_byte,
    output logic              done,
    output logic              irq,
    output logic [DATA_W-1:0] cstat
);
    typedef struct packed {
        logic              en;
        logic              done;
        logic              irq;
        logic [DATA_W-1:0] cstat;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = dma_en;
        if (dma_en && !st_q.en) begin
            st_d.done = 1'b0;
            st_d.irq  = 1'b0;
        end
        if (stat_cap) st_d.cstat = stat_byte;
        if (msg_cap) begin
            st_d.done = 1'b1;
            if (irq_en) st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en    <= 1'b0;
            st_q.done  <= 1'b1;
            st_q.irq   <= 1'b0;
            st_q.cstat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done  = st_q.done | ~dma_en;
    assign irq   = st_q.irq;
    assign cstat = st_q.cstat;
endmodule

// File: rtl/disk_dma_channel.sv
module disk_dma_channel
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              irq_en,
    input  logic              burst_mode,
    input  logic              wide_mode,
    input  logic [PRIO_W-1:0] prio,
    input  logic              addr_wr,
    input  logic [DATA_W-1:0] addr_wdata,
    input  logic              addr_clr,
    input  logic              ctl_req,
    input  logic              ctl_in,
    input  logic              ctl_cmd,
    input  logic              ctl_msg,
    input  logic [DATA_W-1:0] ctl_din,
    output logic [DATA_W-1:0] ctl_dout,
    output logic              ctl_ack,
    output logic              hold_req,
    input  logic              hold_ack,
    output logic [PRIO_W-1:0] arb_code_out,
    input  logic [PRIO_W-1:0] arb_code_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              done,
    output logic              irq,
    output logic [DATA_W-1:0] cstat
);
    typedef struct packed {
        chan_state_e       state;
        logic [DATA_W-1:0] dout;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic addr_inc, stat_cap, msg_cap;
    logic data_phase, stat_phase, arb_won;

    assign data_phase = ctl_req && !ctl_cmd;
    assign stat_phase = ctl_req && ctl_cmd;
    assign arb_won    = hold_ack && (arb_code_in == prio);

    always_comb begin
        fsm_d    = fsm_q;
        addr_inc = 1'b0;
        stat_cap = 1'b0;
        msg_cap  = 1'b0;
        unique case (fsm_q.state)
            ST_IDLE: begin
                if (dma_en) begin
                    if (data_phase) begin
                        fsm_d.state = ST_ARB;
                    end else if (stat_phase) begin
                        stat_cap    = !ctl_msg;
                        msg_cap     = ctl_msg;
                        fsm_d.state = ST_STAT_END;
                    end
                end
            end
            ST_ARB: begin
                if (!dma_en)       fsm_d.state = ST_IDLE;
                else if (hold_ack) fsm_d.state = arb_won ? ST_OWN : ST_BACKOFF;
            end
            ST_BACKOFF: begin
                if (!dma_en)        fsm_d.state = ST_IDLE;
                else if (!hold_ack) fsm_d.state = ST_ARB;
            end
            ST_OWN: begin
                if (!dma_en || stat_phase) fsm_d.state = ST_IDLE;
                else if (data_phase)       fsm_d.state = ST_STROBE;
            end
            ST_STROBE: begin
                if (mem_ready) begin
                    addr_inc = 1'b1;
                    if (ctl_in) fsm_d.dout = mem_rdata;
                    fsm_d.state = ST_HSK_END;
                end
            end
            ST_HSK_END: begin
                if (!ctl_req) fsm_d.state = (burst_mode && dma_en) ? ST_OWN : ST_IDLE;
            end
            ST_STAT_END: begin
                if (!ctl_req) fsm_d.state = ST_IDLE;
            end
            default: fsm_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state <= ST_IDLE;
            fsm_q.dout  <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign hold_req     = (fsm_q.state == ST_ARB) || (fsm_q.state == ST_OWN) ||
                          (fsm_q.state == ST_STROBE) || (fsm_q.state == ST_HSK_END);
    assign arb_code_out = hold_req ? prio : '0;
    assign mem_rd       = (fsm_q.state == ST_STROBE) && ctl_in;
    assign mem_wr       = (fsm_q.state == ST_STROBE) && !ctl_in;
    assign mem_wdata    = ctl_din;
    assign ctl_ack      = (fsm_q.state == ST_HSK_END) || (fsm_q.state == ST_STAT_END);
    assign ctl_dout     = fsm_q.dout;

    dma_addr_ctr #(.ADDR_W(ADDR_W), .BYTE_W(DATA_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (addr_wr),
        .wdata (addr_wdata),
        .clr   (addr_clr),
        .wide  (wide_mode),
        .inc   (addr_inc),
        .addr  (mem_addr)
    );

    dma_status_unit #(.DATA_W(DATA_W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .dma_en    (dma_en),
        .irq_en    (irq_en),
        .stat_cap  (stat_cap),
        .msg_cap   (msg_cap),
        .stat_byte (ctl_din),
        .done      (done),
        .irq       (irq),
        .cstat     (cstat)
    );
endmodule

// File: rtl/dma_channel_checker.sv
module dma_channel_checker #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int PRIO_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dma_en,
    input logic [PRIO_W-1:0] prio,
    input logic              addr_wr,
    input logic              addr_clr,
    input logic              ctl_req,
    input logic              ctl_cmd,
    input logic              ctl_ack,
    input logic              hold_req,
    input logic [PRIO_W-1:0] arb_code_out,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_ready,
    input logic              done
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R6

    AST_STROBE_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> hold_req); // R4

    AST_PRIO_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |-> (arb_code_out == prio)); // R4

    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !mem_ready && !addr_wr && !addr_clr)
        |=> ((mem_rd || mem_wr) && $stable(mem_addr))); // R7

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && mem_ready && !addr_wr && !addr_clr)
        |=> (mem_addr == $past(mem_addr) + 1'b1)); // R8

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        addr_clr |=> (mem_addr == '0)); // R2

    AST_ENABLE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dma_en) && !ctl_req) |=> !done); // R11

    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_ack && ctl_req) |=> ctl_ack); // R12

    AST_STATUS_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_ack && ctl_req && ctl_cmd) |-> !hold_req); // R9
endmodule

bind disk_dma_channel dma_channel_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRIO_W(PRIO_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dma_en       (dma_en),
    .prio         (prio),
    .addr_wr      (addr_wr),
    .addr_clr     (addr_clr),
    .ctl_req      (ctl_req),
    .ctl_cmd      (ctl_cmd),
    .ctl_ack      (ctl_ack),
    .hold_req     (hold_req),
    .arb_code_out (arb_code_out),
    .mem_addr     (mem_addr),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .mem_ready    (mem_ready),
    .done         (done)
);

// File: tb/tb_disk_dma_channel.sv
module tb_disk_dma_channel;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dma_en = 0, irq_en = 0, burst_mode = 0, wide_mode = 1;
    logic [3:0] prio = 4'h6;
    logic addr_wr = 0, addr_clr = 0;
    logic [7:0] addr_wdata = 0;
    logic ctl_req = 0, ctl_in = 0, ctl_cmd = 0, ctl_msg = 0;
    logic [7:0] ctl_din = 0;
    logic [7:0] ctl_dout;
    logic ctl_ack, hold_req;
    logic hold_ack = 0;
    logic [3:0] arb_code_out;
    logic [3:0] arb_code_in = 0;
    logic [23:0] mem_addr;
    logic mem_rd, mem_wr, mem_ready = 0;
    logic [7:0] mem_wdata, mem_rdata;
    logic done, irq;
    logic [7:0] cstat;

    always #(CLK_PERIOD/2) clk = ~clk;

    disk_dma_channel dut (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .irq_en(irq_en),
        .burst_mode(burst_mode), .wide_mode(wide_mode), .prio(prio),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata), .addr_clr(addr_clr),
        .ctl_req(ctl_req), .ctl_in(ctl_in), .ctl_cmd(ctl_cmd), .ctl_msg(ctl_msg),
        .ctl_din(ctl_din), .ctl_dout(ctl_dout), .ctl_ack(ctl_ack),
        .hold_req(hold_req), .hold_ack(hold_ack), .arb_code_out(arb_code_out),
        .arb_code_in(arb_code_in), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .done(done), .irq(irq), .cstat(cstat)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    typedef struct packed {
        logic        wr;
        logic [23:0] a;
        logic [7:0]  d;
    } exp_t;
    exp_t sbq[$];

    int mem_delay = 0;
    int wcnt = 0;
    int strobes = 0;
    bit lose = 0;
    logic [23:0] exp_addr = 0;

    function automatic logic [7:0] mem_model(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction
    assign mem_rdata = mem_model(mem_addr);

    task automatic chk(input string r, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // bus arbiter model: acknowledges one cycle after a request
    always @(negedge clk) begin
        hold_ack    = hold_req;
        arb_code_in = hold_req ? (lose ? (prio ^ 4'hF) : arb_code_out) : 4'h0;
    end

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (mem_rd || mem_wr) begin
            if (wcnt >= mem_delay) begin
                exp_t got;
                mem_ready = 1'b1;
                strobes++;
                chk("R7 strobe length", 40'(wcnt), 40'(mem_delay));
                got = '{wr: mem_wr, a: mem_addr, d: (mem_wr ? mem_wdata : mem_rdata)};
                if (sbq.size() == 0) begin
                    chk("R6 unexpected access", 40'(got), 40'h0);
                end else begin
                    chk("R6 access", 40'(got), 40'(sbq.pop_front()));
                end
            end else begin
                mem_ready = 1'b0;
            end
            wcnt++;
        end else begin
            mem_ready = 1'b0;
            wcnt = 0;
        end
    end

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk);
        addr_wr = 1; addr_wdata = b;
        @(negedge clk);
        addr_wr = 0;
    endtask

    task automatic load3(input logic [23:0] a);
        wide_mode = 1;
        wr_byte(a[23:16]); wr_byte(a[15:8]); wr_byte(a[7:0]);
        exp_addr = a;
    endtask

    task automatic ctl_xfer(input logic din_dir, input logic [7:0] din, input logic cmd,
                            input logic msg, input int extra, output logic [7:0] got);
        int n;
        @(negedge clk);
        ctl_req = 1; ctl_in = din_dir; ctl_din = din; ctl_cmd = cmd; ctl_msg = msg;
        n = 0;
        while (!ctl_ack && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (n >= 400) chk("R12 ack timeout", 40'd0, 40'd1);
        repeat (extra) begin
            @(negedge clk);
            chk("R12 ack held", 40'(ctl_ack), 40'd1);
        end
        got = ctl_dout;
        ctl_req = 0;
        @(negedge clk);
        chk("R12 ack drops", 40'(ctl_ack), 40'd0);
    endtask

    task automatic data_byte(input logic din_dir, input logic [7:0] din);
        logic [7:0] got;
        logic [7:0] ed;
        ed = din_dir ? mem_model(exp_addr) : din;
        sbq.push_back('{wr: !din_dir, a: exp_addr, d: ed});
        ctl_xfer(din_dir, din, 1'b0, 1'b0, 0, got);
        if (din_dir) chk("R6 read data to controller", 40'(got), 40'(ed));
        exp_addr = exp_addr + 1'b1;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] g;
        int hi, lo, s0;
        repeat (3) @(negedge clk);
        chk("R11 done after reset", 40'(done), 40'd1);
        chk("R3 no hold in reset", 40'(hold_req), 40'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R8 pointer reset", 40'(mem_addr), 40'd0);
        chk("R10 irq reset", 40'(irq), 40'd0);

        // R1 wide and narrow loads
        load3(24'h123456);
        chk("R1 wide load", 40'(mem_addr), 40'h123456);
        wide_mode = 0;
        wr_byte(8'hAB); wr_byte(8'hCD);
        chk("R1 narrow load", 40'(mem_addr), 40'h00ABCD);

        // R2 clear beats simultaneous write
        @(negedge clk);
        addr_clr = 1; addr_wr = 1; addr_wdata = 8'h99;
        @(negedge clk);
        addr_clr = 0; addr_wr = 0;
        chk("R2 clear", 40'(mem_addr), 40'd0);

        // R3 disabled channel ignores data request
        @(negedge clk);
        ctl_req = 1; ctl_cmd = 0; ctl_in = 1;
        hi = 0;
        repeat (5) begin
            @(negedge clk);
            if (hold_req) hi++;
        end
        ctl_req = 0;
        chk("R3 no hold while disabled", 40'(hi), 40'd0);
        chk("R11 done while disabled", 40'(done), 40'd1);

        @(negedge clk);
        dma_en = 1; irq_en = 1;
        @(negedge clk);
        chk("R11 enable clears done", 40'(done), 40'd0);

        // R6/R5/R8 single bytes, bus released after each
        load3(24'h000100);
        burst_mode = 0;
        data_byte(1'b1, 8'h00);
        chk("R5 released after byte", 40'(hold_req), 40'd0);
        data_byte(1'b0, 8'h77);
        chk("R8 pointer advanced", 40'(mem_addr), 40'h000102);

        // R7 stretched strobes
        mem_delay = 3;
        data_byte(1'b1, 8'h00);
        data_byte(1'b0, 8'h3E);
        mem_delay = 0;

        // R5 burst keeps the bus; R9 status capture
        burst_mode = 1;
        data_byte(1'b0, 8'h11);
        chk("R5 bus kept in burst", 40'(hold_req), 40'd1);
        data_byte(1'b0, 8'h22);
        chk("R5 bus kept in burst", 40'(hold_req), 40'd1);
        ctl_xfer(1'b0, 8'h3C, 1'b1, 1'b0, 0, g);
        chk("R9 bus released", 40'(hold_req), 40'd0);
        chk("R9 status captured", 40'(cstat), 40'h3C);
        chk("R10 done not yet", 40'(done), 40'd0);
        ctl_xfer(1'b0, 8'h00, 1'b1, 1'b1, 0, g);
        chk("R10 done on msg", 40'(done), 40'd1);
        chk("R10 irq on msg", 40'(irq), 40'd1);

        // R11 disable/enable cycle
        dma_en = 0;
        @(negedge clk);
        chk("R11 done while disabled", 40'(done), 40'd1);
        dma_en = 1;
        @(negedge clk);
        chk("R11 done cleared", 40'(done), 40'd0);
        chk("R11 irq cleared", 40'(irq), 40'd0);

        // R10 without interrupt enable
        irq_en = 0;
        ctl_xfer(1'b0, 8'h81, 1'b1, 1'b0, 0, g);
        chk("R9 second status", 40'(cstat), 40'h81);
        ctl_xfer(1'b0, 8'h00, 1'b1, 1'b1, 0, g);
        chk("R10 done set", 40'(done), 40'd1);
        chk("R10 no irq when disabled", 40'(irq), 40'd0);

        // R8 wrap
        dma_en = 0; @(negedge clk); dma_en = 1; @(negedge clk);
        burst_mode = 0;
        load3(24'hFFFFFF);
        data_byte(1'b0, 8'h5A);
        chk("R8 wrap", 40'(mem_addr), 40'd0);

        // R4 lost arbitration then retry
        lose = 1;
        s0 = strobes;
        hi = 0; lo = 0;
        fork
            data_byte(1'b1, 8'h00);
            begin
                repeat (2) @(negedge clk);
                repeat (10) begin
                    @(negedge clk);
                    if (hold_req) hi++; else lo++;
                end
                chk("R4 no strobe while losing", 40'(strobes), 40'(s0));
                lose = 0;
            end
        join
        chk("R4 retried requests", 40'(hi > 0), 40'd1);
        chk("R4 released on loss", 40'(lo > 0), 40'd1);
        chk("R4 transfer after win", 40'(strobes), 40'(s0 + 1));

        // R12 ack held while request stays up
        ctl_xfer(1'b0, 8'h42, 1'b1, 1'b0, 3, g);
        chk("R9 held status", 40'(cstat), 40'h42);

        repeat (3) @(negedge clk);
        chk("R6 scoreboard drained", 40'(sbq.size()), 40'd0);
        summary();
    end
endmodule